// File: doc/BRIEF.md
# Special-Purpose Register Access Unit

This block serves the move-to and move-from special-register requests of a small processor core. Each register sits at a 16-bit location built from a 5-bit group number in bits 15:11 and an 11-bit index in bits 10:0. The unit keeps the writable system registers locally:

- the vector base, status, previous-PC and the three exception registers
- the power-management register
- the interrupt mask and the interrupt pending set
- a 64-bit multiply-accumulate result

The version word, the configuration words, the core number and the core count are constants set by parameters.

A move-to writes `req_wdata` on the clock edge where `req_mt` is high. A move-from returns its result on `rd_data` in the cycle after `req_mf`, with `rd_valid` marking that cycle. When a read hits no register held here, the result is the `prev_rd` value that came with the request. The translation arrays, the shadow register file and the tick timer live elsewhere. For requests that fall in their ranges, the unit only raises a select line for the cycle of the request.

The unit also reports two events. A write to the power-management register that enables doze or sleep produces a one-cycle halt request, with the resume address set to the current PC plus 4. A write to next-PC produces a one-cycle redirect, which also clears the delay-slot flag, but only when the written value differs from the current PC.

Top module: `spr_access_unit`

## Requirements
- R1: `ext_sel` is high only in a cycle where `req_mt` or `req_mf` is high, and then at most one bit is set. The bits are:
  - bit 0: group 1, index 512..1535
  - bit 1: group 2, index 512..1535
  - bit 2: group 0, index 1024..1535
  - bit 3: group 10, index 0..1
- R2: `rd_data` and `rd_valid` are registered. `rd_valid` is high in exactly the cycles that follow a cycle with `req_mf` high.
- R3: The following are plain read/write registers:
  - vector base (0,11)
  - status (0,17)
  - previous-PC (0,18)
  - exception PC (0,32)
  - exception address (0,48)
  - exception status (0,64)
  - power management (8,0)
  - interrupt mask (9,0)

  After reset each reads 0, except the vector base, which reads `EVBAR_RST`, and the status register, which reads `SR_RST` (supervisor mode, default 1).
- R4: The version word (0,0) reads `VER_VAL & VER_MASK`. The constants at (0,1)..(0,4) read their parameters. Writes to any of these are ignored.
- R5: The accumulator low half (5,1) and high half (5,2) each hold 32 bits of one 64-bit value. A write to one half leaves the other half unchanged.
- R6: The interrupt pending set (9,2) resets to 0.
  - Each `irq_raise` bit sets its pending bit.
  - A write clears every pending bit whose write-data bit is 1.
  - A bit raised in the same cycle as its clear stays set.
- R7: A read of an unmapped location returns `prev_rd`. This includes the locations that are only routed out through `ext_sel`.
- R8: A write to (8,0) with bit 4 (doze) or bit 5 (sleep) set makes `halt_req` high for exactly one cycle after the write. In that cycle `resume_pc` equals `cur_pc` at the time of the write plus 4. Any other write keeps `halt_req` low.
- R9: A write to next-PC (0,16) with a value different from `cur_pc` makes `redirect` high for one cycle after the write, with `redirect_pc` equal to the written value. A write equal to `cur_pc` leaves `redirect` low. A read of (0,16) returns `cur_pc`.
- R10: Core number (0,128) reads `CORE_ID` and core count (0,129) reads `NUM_CORES`. Writes to either are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_addr | input | 16 | Register location, group in 15:11, index in 10:0 |
| req_wdata | input | 32 | Move-to data |
| req_mt | input | 1 | Move-to strobe |
| req_mf | input | 1 | Move-from strobe |
| prev_rd | input | 32 | Previous destination value, returned for unmapped reads |
| cur_pc | input | 32 | Address of the current instruction |
| irq_raise | input | NIRQ | Interrupt pending set inputs |
| rd_data | output | 32 | Move-from result |
| rd_valid | output | 1 | `rd_data` is valid this cycle |
| ext_sel | output | 4 | Selects for external register spaces |
| halt_req | output | 1 | One-cycle halt request |
| resume_pc | output | 32 | PC to resume at after a halt |
| redirect | output | 1 | One-cycle next-PC redirect, also clears the delay-slot flag |
| redirect_pc | output | 32 | Redirect target |

## Verification
The read-back sweep writes distinct, non-repeating data patterns into every local register. Each read carries the same `prev_rd` marker, so a register that was never stored, or a read that wrongly falls through, shows up as that marker value.

The constant locations are written with all ones before they are read. This separates registers that ignore writes from registers that accept them.

The interrupt pending set is driven with:
- raises alone
- partial clears
- a raise and a clear on the same bit in the same cycle

Together these separate clear-on-one from plain overwrite, and show which side wins the collision. The next-PC checks write both the current PC and a different value, which separates the compare from an unconditional redirect.

// File: rtl/spr_pkg.sv
package spr_pkg;
  localparam int ADDR_W = 16;
  localparam int GRP_W  = 5;
  localparam int IDX_W  = 11;
  localparam int XLEN   = 32;

  // group numbers
  localparam logic [GRP_W-1:0] G_SYS  = 5'd0;
  localparam logic [GRP_W-1:0] G_DTR  = 5'd1;
  localparam logic [GRP_W-1:0] G_ITR  = 5'd2;
  localparam logic [GRP_W-1:0] G_MAC  = 5'd5;
  localparam logic [GRP_W-1:0] G_PWR  = 5'd8;
  localparam logic [GRP_W-1:0] G_PIC  = 5'd9;
  localparam logic [GRP_W-1:0] G_TICK = 5'd10;

  // external range bounds (inclusive)
  localparam int TR_LO  = 512;
  localparam int TR_HI  = 1535;
  localparam int SHD_LO = 1024;
  localparam int SHD_HI = 1535;
  localparam int TICK_HI = 1;

  localparam int EXT_N   = 4;
  localparam int EXT_DTR = 0;
  localparam int EXT_ITR = 1;
  localparam int EXT_SHD = 2;
  localparam int EXT_TMR = 3;

  localparam int PWR_DOZE_BIT  = 4;
  localparam int PWR_SLEEP_BIT = 5;

  typedef enum logic [4:0] {
    SPR_NONE, SPR_VER, SPR_UPR, SPR_CPUCFG, SPR_DMMUCFG, SPR_IMMUCFG,
    SPR_EVBAR, SPR_NPC, SPR_SR, SPR_PPC, SPR_EPCR, SPR_EEAR, SPR_ESR,
    SPR_COREID, SPR_NCORES, SPR_MACLO, SPR_MACHI, SPR_PMR, SPR_PICMR,
    SPR_PICSR
  } spr_id_e;

  // plain read/write register slots
  localparam int PLAIN_N = 7;
  localparam int P_EVBAR = 0;
  localparam int P_SR    = 1;
  localparam int P_PPC   = 2;
  localparam int P_EPCR  = 3;
  localparam int P_EEAR  = 4;
  localparam int P_ESR   = 5;
  localparam int P_PMR   = 6;

  function automatic spr_id_e plain_id(input int k);
    case (k)
      P_EVBAR: return SPR_EVBAR;
      P_SR:    return SPR_SR;
      P_PPC:   return SPR_PPC;
      P_EPCR:  return SPR_EPCR;
      P_EEAR:  return SPR_EEAR;
      P_ESR:   return SPR_ESR;
      default: return SPR_PMR;
    endcase
  endfunction

  function automatic logic [ADDR_W-1:0] spr_loc(input int grp, input int idx);
    return ADDR_W'((grp << IDX_W) + idx);
  endfunction
endpackage

// File: rtl/spr_decode.sv
module spr_decode
  import spr_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  output spr_id_e           id,
  output logic [EXT_N-1:0]  region
);
  logic [GRP_W-1:0] grp;
  logic [IDX_W-1:0] idx;
  assign grp = addr[ADDR_W-1 -: GRP_W];
  assign idx = addr[IDX_W-1:0];

  always_comb begin
    id = SPR_NONE;
    case (grp)
      G_SYS: begin
        case (idx)
          11'd0:   id = SPR_VER;
          11'd1:   id = SPR_UPR;
          11'd2:   id = SPR_CPUCFG;
          11'd3:   id = SPR_DMMUCFG;
          11'd4:   id = SPR_IMMUCFG;
          11'd11:  id = SPR_EVBAR;
          11'd16:  id = SPR_NPC;
          11'd17:  id = SPR_SR;
          11'd18:  id = SPR_PPC;
          11'd32:  id = SPR_EPCR;
          11'd48:  id = SPR_EEAR;
          11'd64:  id = SPR_ESR;
          11'd128: id = SPR_COREID;
          11'd129: id = SPR_NCORES;
          default: id = SPR_NONE;
        endcase
      end
      G_MAC: begin
        if (idx == 11'd1)      id = SPR_MACLO;
        else if (idx == 11'd2) id = SPR_MACHI;
      end
      G_PWR: if (idx == 11'd0) id = SPR_PMR;
      G_PIC: begin
        if (idx == 11'd0)      id = SPR_PICMR;
        else if (idx == 11'd2) id = SPR_PICSR;
      end
      default: id = SPR_NONE;
    endcase
  end

  always_comb begin
    region          = '0;
    region[EXT_DTR] = (grp == G_DTR) && (int'(idx) >= TR_LO) && (int'(idx) <= TR_HI);
    region[EXT_ITR] = (grp == G_ITR) && (int'(idx) >= TR_LO) && (int'(idx) <= TR_HI);
    region[EXT_SHD] = (grp == G_SYS) && (int'(idx) >= SHD_LO) && (int'(idx) <= SHD_HI);
    region[EXT_TMR] = (grp == G_TICK) && (int'(idx) <= TICK_HI);
  end
endmodule

// File: rtl/spr_sysregs.sv
module spr_sysregs
  import spr_pkg::*;
#(
  parameter logic [31:0] EVBAR_RST = 32'h0,
  parameter logic [31:0] SR_RST    = 32'h1,
  parameter int          NIRQ      = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  spr_id_e          id,
  input  logic [XLEN-1:0]  wdata,
  input  logic [NIRQ-1:0]  irq_raise,
  output logic [XLEN-1:0]  plain_q [PLAIN_N],
  output logic [NIRQ-1:0]  mask_q,
  output logic [NIRQ-1:0]  pend_q
);
  for (genvar k = 0; k < PLAIN_N; k++) begin : g_plain
    localparam logic [XLEN-1:0] RST = (k == P_EVBAR) ? EVBAR_RST :
                                      (k == P_SR)    ? SR_RST : '0;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          plain_q[k] <= RST;
      else if (we && id == plain_id(k))    plain_q[k] <= wdata;
    end
  end

  logic [NIRQ-1:0] clr;
  assign clr = (we && id == SPR_PICSR) ? wdata[NIRQ-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      pend_q <= '0;
    end else begin
      if (we && id == SPR_PICMR) mask_q <= wdata[NIRQ-1:0];
      pend_q <= (pend_q & ~clr) | irq_raise;
    end
  end
endmodule

// File: rtl/spr_accum.sv
module spr_accum
  import spr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  spr_id_e           id,
  input  logic [XLEN-1:0]   wdata,
  output logic [2*XLEN-1:0] acc_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else if (we && id == SPR_MACLO) acc_q[XLEN-1:0]      <= wdata;
    else if (we && id == SPR_MACHI) acc_q[2*XLEN-1:XLEN] <= wdata;
  end
endmodule

// File: rtl/spr_rdmux.sv
module spr_rdmux
  import spr_pkg::*;
#(
  parameter logic [31:0] VER_VAL     = 32'h0,
  parameter logic [31:0] VER_MASK    = 32'h0,
  parameter logic [31:0] UPR_VAL     = 32'h0,
  parameter logic [31:0] CPUCFG_VAL  = 32'h0,
  parameter logic [31:0] DMMUCFG_VAL = 32'h0,
  parameter logic [31:0] IMMUCFG_VAL = 32'h0,
  parameter logic [31:0] CORE_ID     = 32'h0,
  parameter logic [31:0] NUM_CORES   = 32'h1,
  parameter int          NIRQ        = 32
) (
  input  spr_id_e           id,
  input  logic [XLEN-1:0]   prev_rd,
  input  logic [XLEN-1:0]   cur_pc,
  input  logic [XLEN-1:0]   plain_q [PLAIN_N],
  input  logic [NIRQ-1:0]   mask_q,
  input  logic [NIRQ-1:0]   pend_q,
  input  logic [2*XLEN-1:0] acc_q,
  output logic [XLEN-1:0]   rd_next
);
  always_comb begin
    case (id)
      SPR_VER:     rd_next = VER_VAL & VER_MASK;
      SPR_UPR:     rd_next = UPR_VAL;
      SPR_CPUCFG:  rd_next = CPUCFG_VAL;
      SPR_DMMUCFG: rd_next = DMMUCFG_VAL;
      SPR_IMMUCFG: rd_next = IMMUCFG_VAL;
      SPR_EVBAR:   rd_next = plain_q[P_EVBAR];
      SPR_NPC:     rd_next = cur_pc;
      SPR_SR:      rd_next = plain_q[P_SR];
      SPR_PPC:     rd_next = plain_q[P_PPC];
      SPR_EPCR:    rd_next = plain_q[P_EPCR];
      SPR_EEAR:    rd_next = plain_q[P_EEAR];
      SPR_ESR:     rd_next = plain_q[P_ESR];
      SPR_COREID:  rd_next = CORE_ID;
      SPR_NCORES:  rd_next = NUM_CORES;
      SPR_MACLO:   rd_next = acc_q[XLEN-1:0];
      SPR_MACHI:   rd_next = acc_q[2*XLEN-1:XLEN];
      SPR_PMR:     rd_next = plain_q[P_PMR];
      SPR_PICMR:   rd_next = XLEN'(mask_q);
      SPR_PICSR:   rd_next = XLEN'(pend_q);
      default:     rd_next = prev_rd;
    endcase
  end
endmodule

// File: rtl/spr_access_unit.sv
module spr_access_unit
  import spr_pkg::*;
#(
  parameter logic [31:0] VER_VAL     = 32'h1200_0001,
  parameter logic [31:0] VER_MASK    = 32'hFF00_003F,
  parameter logic [31:0] UPR_VAL     = 32'h0000_0619,
  parameter logic [31:0] CPUCFG_VAL  = 32'h0000_0020,
  parameter logic [31:0] DMMUCFG_VAL = 32'h0000_0018,
  parameter logic [31:0] IMMUCFG_VAL = 32'h0000_0018,
  parameter logic [31:0] EVBAR_RST   = 32'h0000_0000,
  parameter logic [31:0] SR_RST      = 32'h0000_0001,
  parameter logic [31:0] CORE_ID     = 32'h0000_0000,
  parameter logic [31:0] NUM_CORES   = 32'h0000_0001,
  parameter int          NIRQ        = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [15:0]      req_addr,
  input  logic [31:0]      req_wdata,
  input  logic             req_mt,
  input  logic             req_mf,
  input  logic [31:0]      prev_rd,
  input  logic [31:0]      cur_pc,
  input  logic [NIRQ-1:0]  irq_raise,
  output logic [31:0]      rd_data,
  output logic             rd_valid,
  output logic [3:0]       ext_sel,
  output logic             halt_req,
  output logic [31:0]      resume_pc,
  output logic             redirect,
  output logic [31:0]      redirect_pc
);
  spr_id_e            id;
  logic [EXT_N-1:0]   region;
  logic [XLEN-1:0]    plain_q [PLAIN_N];
  logic [NIRQ-1:0]    mask_q;
  logic [NIRQ-1:0]    pend_q;
  logic [2*XLEN-1:0]  acc_q;
  logic [XLEN-1:0]    rd_next;
  logic               halt_hit;
  logic               jump_hit;

  spr_decode u_dec (
    .addr   (req_addr),
    .id     (id),
    .region (region)
  );

  spr_sysregs #(.EVBAR_RST(EVBAR_RST), .SR_RST(SR_RST), .NIRQ(NIRQ)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .we        (req_mt),
    .id        (id),
    .wdata     (req_wdata),
    .irq_raise (irq_raise),
    .plain_q   (plain_q),
    .mask_q    (mask_q),
    .pend_q    (pend_q)
  );

  spr_accum u_acc (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (req_mt),
    .id    (id),
    .wdata (req_wdata),
    .acc_q (acc_q)
  );

  spr_rdmux #(
    .VER_VAL(VER_VAL), .VER_MASK(VER_MASK), .UPR_VAL(UPR_VAL),
    .CPUCFG_VAL(CPUCFG_VAL), .DMMUCFG_VAL(DMMUCFG_VAL),
    .IMMUCFG_VAL(IMMUCFG_VAL), .CORE_ID(CORE_ID),
    .NUM_CORES(NUM_CORES), .NIRQ(NIRQ)
  ) u_mux (
    .id      (id),
    .prev_rd (prev_rd),
    .cur_pc  (cur_pc),
    .plain_q (plain_q),
    .mask_q  (mask_q),
    .pend_q  (pend_q),
    .acc_q   (acc_q),
    .rd_next (rd_next)
  );

  assign ext_sel  = region & {EXT_N{req_mt | req_mf}};
  assign halt_hit = req_mt && (id == SPR_PMR) &&
                    (req_wdata[PWR_DOZE_BIT] || req_wdata[PWR_SLEEP_BIT]);
  assign jump_hit = req_mt && (id == SPR_NPC) && (req_wdata != cur_pc);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data     <= '0;
      rd_valid    <= 1'b0;
      halt_req    <= 1'b0;
      resume_pc   <= '0;
      redirect    <= 1'b0;
      redirect_pc <= '0;
    end else begin
      rd_valid <= req_mf;
      if (req_mf)   rd_data     <= rd_next;
      halt_req <= halt_hit;
      if (halt_hit) resume_pc   <= cur_pc + 32'd4;
      redirect <= jump_hit;
      if (jump_hit) redirect_pc <= req_wdata;
    end
  end
endmodule

// File: rtl/spr_access_unit_chk.sv
module spr_access_unit_chk
  import spr_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] req_addr,
  input logic [31:0] req_wdata,
  input logic        req_mt,
  input logic        req_mf,
  input logic [31:0] prev_rd,
  input logic [31:0] cur_pc,
  input logic [31:0] rd_data,
  input logic        rd_valid,
  input logic [3:0]  ext_sel,
  input logic        halt_req,
  input logic [31:0] resume_pc,
  input logic        redirect,
  input logic [31:0] redirect_pc
);
  localparam logic [15:0] A_PWR = spr_loc(8, 0);
  localparam logic [15:0] A_NPC = spr_loc(0, 16);

  assert_ext_onehot_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ext_sel));

  assert_ext_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_mt || req_mf) |-> ext_sel == 4'b0000);

  assert_rvalid_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_mf |=> rd_valid);

  assert_rvalid_clr_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !req_mf |=> !rd_valid);

  // group 3 holds nothing, so reads there fall through
  assert_unmapped_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_mf && req_addr[15:11] == 5'd3) |=> rd_data == $past(prev_rd));

  assert_halt_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_mt && req_addr == A_PWR && req_wdata[5:4] != 2'b00)
      |=> (halt_req && resume_pc == $past(cur_pc) + 32'd4));

  assert_halt_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(halt_req) |-> $past(req_mt));

  assert_npc_same_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_mt && req_addr == A_NPC && req_wdata == cur_pc) |=> !redirect);

  assert_npc_diff_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_mt && req_addr == A_NPC && req_wdata != cur_pc)
      |=> (redirect && redirect_pc == $past(req_wdata)));
endmodule

bind spr_access_unit spr_access_unit_chk i_chk (
  .clk(clk), .rst_n(rst_n), .req_addr(req_addr), .req_wdata(req_wdata),
  .req_mt(req_mt), .req_mf(req_mf), .prev_rd(prev_rd), .cur_pc(cur_pc),
  .rd_data(rd_data), .rd_valid(rd_valid), .ext_sel(ext_sel),
  .halt_req(halt_req), .resume_pc(resume_pc), .redirect(redirect),
  .redirect_pc(redirect_pc)
);

// File: tb/test_spr_access_unit.sv
`timescale 1ns/1ps
module test_spr_access_unit;
  localparam logic [31:0] VER_V  = 32'h1234_0056;
  localparam logic [31:0] VER_M  = 32'hFF00_003F;
  localparam logic [31:0] EVB_R  = 32'h0000_0100;
  localparam logic [31:0] SR_R   = 32'h0000_0001;
  localparam logic [31:0] CID    = 32'h0000_0003;
  localparam logic [31:0] NCORE  = 32'h0000_0004;
  localparam logic [31:0] MARK   = 32'hDEAD_BEEF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        req_mt = 1'b0;
  logic        req_mf = 1'b0;
  logic [31:0] prev_rd = '0;
  logic [31:0] cur_pc = '0;
  logic [31:0] irq_raise = '0;
  logic [31:0] rd_data;
  logic        rd_valid;
  logic [3:0]  ext_sel;
  logic        halt_req;
  logic [31:0] resume_pc;
  logic        redirect;
  logic [31:0] redirect_pc;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  spr_access_unit #(
    .VER_VAL(VER_V), .VER_MASK(VER_M), .EVBAR_RST(EVB_R), .SR_RST(SR_R),
    .CORE_ID(CID), .NUM_CORES(NCORE), .NIRQ(32)
  ) i_spr_access_unit (
    .clk(clk), .rst_n(rst_n), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_mt(req_mt), .req_mf(req_mf), .prev_rd(prev_rd), .cur_pc(cur_pc),
    .irq_raise(irq_raise), .rd_data(rd_data), .rd_valid(rd_valid),
    .ext_sel(ext_sel), .halt_req(halt_req), .resume_pc(resume_pc),
    .redirect(redirect), .redirect_pc(redirect_pc)
  );

  // write-then-read vectors: location, write data, expected read, requirement
  localparam int NV = 15;
  localparam logic [15:0] T_ADDR [NV] = '{
    16'h000B, 16'h0011, 16'h0012, 16'h0020, 16'h0040, 16'h0030, 16'h4800,
    16'h2802, 16'h2801, 16'h0000, 16'h0080, 16'h0081, 16'h1805, 16'h0A58,
    16'h4000};
  localparam logic [31:0] T_WD [NV] = '{
    32'h1234_5600, 32'h0000_8001, 32'hCAFE_0004, 32'h0000_2000,
    32'h0000_0003, 32'hA5A5_5A5A, 32'hFFFF_0F0F, 32'h3333_4444,
    32'h1111_2222, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF,
    32'h0BAD_F00D, 32'h0BAD_F00D, 32'h0000_0001};
  localparam logic [31:0] T_EXP [NV] = '{
    32'h1234_5600, 32'h0000_8001, 32'hCAFE_0004, 32'h0000_2000,
    32'h0000_0003, 32'hA5A5_5A5A, 32'hFFFF_0F0F, 32'h3333_4444,
    32'h1111_2222, 32'h1200_0016, 32'h0000_0003, 32'h0000_0004,
    32'hDEAD_BEEF, 32'hDEAD_BEEF, 32'h0000_0001};
  // rows 0-6 and 14: R3; rows 7-8: R5; row 9: R4; rows 10-11: R10; rows 12-13: R7
  localparam int T_REQ [NV] = '{3, 3, 3, 3, 3, 3, 3, 5, 5, 4, 10, 10, 7, 7, 3};

  task automatic check(input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  task automatic do_write(input logic [15:0] a, input logic [31:0] d);
    @(negedge clk);
    req_addr = a; req_wdata = d; req_mt = 1'b1;
    @(negedge clk);
    req_mt = 1'b0;
  endtask

  task automatic do_read(input logic [15:0] a, output logic [31:0] v, output logic vld);
    @(negedge clk);
    req_addr = a; prev_rd = MARK; req_mf = 1'b1;
    @(negedge clk);
    req_mf = 1'b0;
    v = rd_data; vld = rd_valid;
  endtask

  task automatic sel_probe(input logic [15:0] a, input logic [3:0] exp);
    @(negedge clk);
    req_addr = a; req_mf = 1'b1;
    #1 check("R1", "ext_sel", {28'h0, ext_sel}, {28'h0, exp});
    @(negedge clk);
    req_mf = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    logic vld;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // reset state
    check("R2", "rd_valid after reset", {31'h0, rd_valid}, 32'h0);
    check("R8", "halt_req after reset", {31'h0, halt_req}, 32'h0);
    check("R9", "redirect after reset", {31'h0, redirect}, 32'h0);
    do_read(16'h000B, v, vld); check("R3", "vector base reset", v, EVB_R);
    check("R2", "rd_valid after read", {31'h0, vld}, 32'h1);
    do_read(16'h0011, v, vld); check("R3", "status reset", v, SR_R);
    do_read(16'h0012, v, vld); check("R3", "previous-PC reset", v, 32'h0);
    do_read(16'h4802, v, vld); check("R6", "pending reset", v, 32'h0);
    do_read(16'h2801, v, vld); check("R5", "acc low reset", v, 32'h0);
    @(negedge clk);
    check("R2", "rd_valid idle", {31'h0, rd_valid}, 32'h0);

    // table walk
    for (int i = 0; i < NV; i++) begin
      do_write(T_ADDR[i], T_WD[i]);
      check("R2", "rd_valid after write", {31'h0, rd_valid}, 32'h0);
      do_read(T_ADDR[i], v, vld);
      checks++;
      if (v !== T_EXP[i] || vld !== 1'b1) begin
        errors++;
        $display("FAIL R%0d vector %0d: actual %h expected %h", T_REQ[i], i, v, T_EXP[i]);
      end
    end

    // R5 halves independent
    do_write(16'h2801, 32'h5555_6666);
    do_read(16'h2802, v, vld); check("R5", "acc high kept", v, 32'h3333_4444);
    do_read(16'h2801, v, vld); check("R5", "acc low new", v, 32'h5555_6666);

    // R6 pending set: raise, clear, collision
    @(negedge clk); irq_raise = 32'h0000_00F0;
    @(negedge clk); irq_raise = 32'h0;
    do_read(16'h4802, v, vld); check("R6", "raise", v, 32'h0000_00F0);
    do_write(16'h4802, 32'h0000_0030);
    do_read(16'h4802, v, vld); check("R6", "clear-on-one", v, 32'h0000_00C0);
    @(negedge clk);
    req_addr = 16'h4802; req_wdata = 32'h0000_0040; req_mt = 1'b1; irq_raise = 32'h0000_0041;
    @(negedge clk);
    req_mt = 1'b0; irq_raise = 32'h0;
    do_read(16'h4802, v, vld); check("R6", "raise beats clear", v, 32'h0000_00C1);
    do_read(16'h4800, v, vld); check("R3", "mask untouched", v, 32'hFFFF_0F0F);

    // R8 halt
    cur_pc = 32'h0000_1000;
    do_write(16'h4000, 32'h0000_0001);
    check("R8", "no halt without enables", {31'h0, halt_req}, 32'h0);
    do_write(16'h4000, 32'h0000_0010);
    check("R8", "doze halt", {31'h0, halt_req}, 32'h1);
    check("R8", "resume pc", resume_pc, 32'h0000_1004);
    @(negedge clk);
    check("R8", "halt one cycle", {31'h0, halt_req}, 32'h0);
    cur_pc = 32'h0000_2220;
    do_write(16'h4000, 32'h0000_0020);
    check("R8", "sleep halt", {31'h0, halt_req}, 32'h1);
    check("R8", "resume pc sleep", resume_pc, 32'h0000_2224);

    // R9 next-PC
    cur_pc = 32'h0000_2000;
    do_write(16'h0010, 32'h0000_2000);
    check("R9", "same pc no redirect", {31'h0, redirect}, 32'h0);
    do_write(16'h0010, 32'h0000_3000);
    check("R9", "redirect", {31'h0, redirect}, 32'h1);
    check("R9", "redirect target", redirect_pc, 32'h0000_3000);
    @(negedge clk);
    check("R9", "redirect one cycle", {31'h0, redirect}, 32'h0);
    do_read(16'h0010, v, vld); check("R9", "npc read", v, 32'h0000_2000);

    // R1 selects
    sel_probe(16'h0A58, 4'b0001);
    sel_probe(16'h1200, 4'b0010);
    sel_probe(16'h0400, 4'b0100);
    sel_probe(16'h5001, 4'b1000);
    sel_probe(16'h0864, 4'b0000);
    @(negedge clk); req_addr = 16'h0A58;
    #1 check("R1", "idle select", {28'h0, ext_sel}, 32'h0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule